// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Input Stage

This block is the digital front end of a 12-bit voltage-output converter. A host places a code on a parallel bus, pulls an active-low select low and raises a write strobe. On the rising strobe edge the code is stored in a holding register. A separate active-low load input copies the holding register into the converter register. The converter register is the value that drives the analog core.

With load tied low, each write reaches the converter register as soon as it is captured. When load is driven low only after the write, several values can be staged and then applied at a chosen moment. An active-low power-down input forces the reported converter value to zero and raises a flag. Both registers keep their contents while powered down.

All host inputs are asynchronous to the system clock. They pass through a two-stage synchronizer before any edge detection. The data bus passes through the same depth, so data and strobe arrive aligned. Reset is synchronous and active high, and it acts as the power-on reset.

Top module: `dacfe_top`

## Requirements
- R1: While reset is high and after it is released, the holding and converter registers are zero, `dac_code_o` reads 0x000 and `pwr_down_o` reads 0.
- R2: A rising edge on `wr_i` while `sel_n_i` is low stores the 12-bit value on `data_i` in the holding register. `data_i` must be held stable from one clock before the edge until the strobe falls.
- R3: A strobe edge while `sel_n_i` is high leaves both registers unchanged.
- R4: While `load_n_i` is low, the converter register takes the holding register value.
- R5: With `load_n_i` held low, a write appears on `dac_code_o` on the fourth rising clock edge after `wr_i` rises at the port, with no separate update step. Code 0x000 and code 0xFFF both pass unchanged.
- R6: With `load_n_i` high, `dac_code_o` keeps its previous value after a write until `load_n_i` goes low.
- R7: On the third rising clock edge after `pwr_n_i` goes low, `dac_code_o` reads 0x000 and `pwr_down_o` reads 1.
- R8: Power-down keeps both registers, and writes during power-down are still captured. On exit, `dac_code_o` returns to the converter register value.
- R9: Only the strobe edge captures data. Changes on `data_i` while `wr_i` stays high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| wr_i | input | 1 | Write strobe, captures on its rising edge, asynchronous |
| load_n_i | input | 1 | Active-low transfer of the holding value to the converter register |
| pwr_n_i | input | 1 | Active-low power-down request |
| data_i | input | 12 | Parallel code bus |
| dac_code_o | output | 12 | Registered converter code; zero while powered down |
| pwr_down_o | output | 1 | Registered powered-down flag |

## Verification
The hardest case to reach is a deferred update that spans a power-down. The bench stages a code with load high while powered down, leaves power-down, and only then pulses load. The old value must reappear first and the staged value must appear only after the pulse. A second awkward case is a strobe held high while the data bus moves. The bench changes the bus in the middle of a long strobe with load low, so any level-sensitive capture would show at the output. A behavioural model fed from a history of port samples is compared with both outputs on every clock.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int CODE_W_DEF = 12;
  localparam int SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic sel_n;
    logic wr;
    logic load_n;
    logic pwr_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, wr: 1'b0, load_n: 1'b1, pwr_n: 1'b1};
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacfe_strobe_detect.sv
module dacfe_strobe_detect (
  input  logic clk,
  input  logic rst,
  input  logic wr_s,
  input  logic sel_n_s,
  output logic capture
);
  logic wr_prev;

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b0;
    else     wr_prev <= wr_s;
  end

  assign capture = wr_s & ~wr_prev & ~sel_n_s;

  assert_capture_needs_select_R3: assert property (@(posedge clk) disable iff (rst)
    capture |-> !sel_n_s);
  assert_single_capture_R9: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture);
endmodule

// File: rtl/dacfe_latches.sv
module dacfe_latches #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] code_in,
  input  logic         load_n,
  output logic [W-1:0] hold_q,
  output logic [W-1:0] dac_q
);
  logic [W-1:0] hold_nxt;

  assign hold_nxt = capture ? code_in : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      dac_q  <= '0;
    end else begin
      hold_q <= hold_nxt;
      if (!load_n) dac_q <= hold_nxt;
    end
  end

  assert_hold_only_on_capture_R2: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(hold_q));
  assert_dac_kept_when_no_load_R6: assert property (@(posedge clk) disable iff (rst)
    load_n |=> $stable(dac_q));
  assert_load_copies_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !capture) |=> dac_q == $past(hold_q));
  assert_transparent_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!load_n && capture) |=> dac_q == $past(code_in));
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
  parameter int CODE_W = dacfe_pkg::CODE_W_DEF,
  parameter int SYNC_STAGES = dacfe_pkg::SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_i,
  input  logic              wr_i,
  input  logic              load_n_i,
  input  logic              pwr_n_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              pwr_down_o
);
  import dacfe_pkg::*;

  localparam int CTL_W = $bits(ctl_t);

  ctl_t ctl_raw, ctl_s;
  logic [CTL_W-1:0] ctl_s_bits;
  logic [CODE_W-1:0] data_s, hold_q, dac_q;
  logic capture;

  assign ctl_raw = '{sel_n: sel_n_i, wr: wr_i, load_n: load_n_i, pwr_n: pwr_n_i};

  dacfe_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s_bits));
  assign ctl_s = ctl_t'(ctl_s_bits);

  dacfe_sync #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst(rst), .d(data_i), .q(data_s));

  dacfe_strobe_detect u_detect (
    .clk(clk), .rst(rst), .wr_s(ctl_s.wr), .sel_n_s(ctl_s.sel_n), .capture(capture));

  dacfe_latches #(.W(CODE_W)) u_latches (
    .clk(clk), .rst(rst), .capture(capture), .code_in(data_s),
    .load_n(ctl_s.load_n), .hold_q(hold_q), .dac_q(dac_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code_o <= '0;
      pwr_down_o <= 1'b0;
    end else begin
      dac_code_o <= ctl_s.pwr_n ? dac_q : '0;
      pwr_down_o <= ~ctl_s.pwr_n;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (dac_code_o == '0 && !pwr_down_o && hold_q == '0 && dac_q == '0));
  assert_select_high_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    ctl_s.sel_n |=> $stable(hold_q));
  assert_pd_forces_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !ctl_s.pwr_n |=> (dac_code_o == '0 && pwr_down_o));
  assert_active_shows_latch_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_s.pwr_n |=> (dac_code_o == $past(dac_q) && !pwr_down_o));
endmodule

// File: tb/dacfe_top_test.sv
module dacfe_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, wr = 1'b0, load_n = 1'b1, pwr_n = 1'b1;
  logic [W-1:0] data = '0;
  logic [W-1:0] dac_code;
  logic pwr_down;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  dacfe_top uut (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .wr_i(wr), .load_n_i(load_n),
    .pwr_n_i(pwr_n), .data_i(data), .dac_code_o(dac_code), .pwr_down_o(pwr_down));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: history of port samples, newest at index 0.
  typedef struct {bit sel_n; bit wr; bit load_n; bit pwr_n; int code;} smp_t;
  smp_t hist [4];
  int m_hold = 0, m_dac = 0, m_out = 0;
  bit m_pd = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) hist[i] = '{1, 0, 1, 1, 0};
      m_hold = 0; m_dac = 0; m_out = 0; m_pd = 0;
    end else begin
      bit rise;
      int nh;
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = '{sel_n, wr, load_n, pwr_n, int'(data)};
      m_out = hist[2].pwr_n ? m_dac : 0;
      m_pd  = !hist[2].pwr_n;
      rise = hist[2].wr && !hist[3].wr && !hist[2].sel_n;
      nh = rise ? hist[2].code : m_hold;
      if (!hist[2].load_n) m_dac = nh;
      m_hold = nh;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (int'(dac_code) != m_out || pwd_mismatch()) begin
        errors++;
        $display("FAIL %s model compare: code=%h pd=%b expected code=%h pd=%b",
                 phase, dac_code, pwr_down, m_out[W-1:0], m_pd);
      end
    end
  end

  function automatic bit pwd_mismatch();
    return pwr_down != m_pd;
  endfunction

  task automatic check(string req, logic [W-1:0] exp_code, logic exp_pd);
    checks++;
    if (dac_code !== exp_code || pwr_down !== exp_pd) begin
      errors++;
      $display("FAIL %s: code=%h pd=%b expected code=%h pd=%b",
               req, dac_code, pwr_down, exp_code, exp_pd);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_code(logic [W-1:0] code, logic sel);
    data = code; sel_n = sel; tick(1);
    wr = 1'b1; tick(4);
    wr = 1'b0; tick(2);
    sel_n = 1'b1; tick(1);
  endtask

  task automatic load_pulse();
    load_n = 1'b0; tick(2);
    load_n = 1'b1; tick(4);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    tick(1);
    check("R1 during reset", 12'h000, 1'b0);
    tick(3);
    rst = 1'b0;
    tick(4);
    check("R1 after reset", 12'h000, 1'b0);

    phase = "R6";
    write_code(12'h5A3, 1'b0);
    tick(4);
    check("R6 deferred output unchanged", 12'h000, 1'b0);
    phase = "R4";
    load_pulse();
    check("R4 R2 load applies captured code", 12'h5A3, 1'b0);

    phase = "R3";
    write_code(12'h111, 1'b1);
    load_pulse();
    check("R3 deselected write ignored", 12'h5A3, 1'b0);

    phase = "R5";
    load_n = 1'b0; tick(4);
    data = 12'hFFF; sel_n = 1'b0; tick(1);
    wr = 1'b1; tick(3);
    check("R5 not yet at third edge", 12'h5A3, 1'b0);
    tick(1);
    check("R5 code 0xFFF at fourth edge", 12'hFFF, 1'b0);
    wr = 1'b0; tick(2); sel_n = 1'b1; tick(1);
    write_code(12'h000, 1'b0);
    tick(2);
    check("R5 code 0x000 passes", 12'h000, 1'b0);

    phase = "R9";
    data = 12'h2B7; sel_n = 1'b0; tick(1);
    wr = 1'b1; tick(5);
    data = 12'h321; tick(6);
    check("R9 level on strobe ignored", 12'h2B7, 1'b0);
    wr = 1'b0; tick(2); sel_n = 1'b1; tick(2);

    phase = "R7";
    write_code(12'h7C4, 1'b0);
    tick(2);
    pwr_n = 1'b0; tick(2);
    check("R7 not yet down at second edge", 12'h7C4, 1'b0);
    tick(1);
    check("R7 powered down output zero", 12'h000, 1'b1);

    phase = "R8";
    load_n = 1'b1; tick(2);
    write_code(12'h0AB, 1'b0);
    tick(2);
    check("R8 still zero while down", 12'h000, 1'b1);
    pwr_n = 1'b1; tick(4);
    check("R8 restored on exit", 12'h7C4, 1'b0);
    load_pulse();
    check("R8 code captured during power-down", 12'h0AB, 1'b0);

    tick(4);
    finish_run();
  end
endmodule